// File: doc/BRIEF.md
# VCONN Overcurrent Soft-Start Monitor

This block decides when a VCONN overcurrent reading is a real fault. It takes two synchronized comparator outputs from the analog sense path. One compares against a high inrush threshold of about 590 mA. The other compares against the normal threshold of about 47 mA nominal. The block also takes the closed state of the VCONN switch and the power-mode status of the device.

Each time the switch closes while the device is in normal power mode, a soft-start window opens. For the length of that window only the inrush comparator can cause a trip. When the window has run out, the normal comparator becomes the one that counts.

A qualified overcurrent leaves the block as a single-cycle pulse to the fault sequencer. While the sequencer reports that it is in alarm, no new pulse is raised. The window length is a parameter in clock cycles. Its default is derived from the clock frequency and a duration of 600 µs, which lies inside the permitted span of 512 µs to 1 ms.

Top module: `vconn_ocp_gate`

## Requirements
- R1: `ocp_trip` is 0 in every cycle while `rst` is high and in the first cycle after `rst` is released, whatever the other inputs are.
- R2: The window opens on the first rising clock edge at which `pwr_normal` and `vconn_closed` are both 1 after either of them was 0. It lasts exactly `WIN_CYCLES` clock cycles. With `cmp_normal` held at 1 from that point on, `ocp_trip` is first 1 in the sample taken `WIN_CYCLES`+2 edges after the inputs were applied, and not before.
- R3: While the window is open, `cmp_normal` has no effect on `ocp_trip`, and `cmp_inrush`=1 causes a trip.
- R4: After the window, `cmp_normal`=1 causes a trip, and `cmp_inrush`=1 with `cmp_normal`=0 causes none.
- R5: `ocp_trip` rises on the first clock edge at which the active comparator is seen at 1. That is one cycle of latency, well inside the 2 µs limit at any clock above 0.5 MHz.
- R6: Each trip is a pulse exactly one cycle wide. No further pulse follows until the active comparator has returned to 0.
- R7: While `seq_alarm` is 1, `ocp_trip` stays 0. If the active comparator is still 1 when `seq_alarm` falls, a pulse follows on the next edge.
- R8: Opening the switch cancels the window. Closing it again starts a full window from zero.
- R9: While `pwr_normal` is 0, `ocp_trip` stays 0 and the window is cancelled. Returning to normal mode with the switch closed starts a fresh window.
- R10: While `vconn_closed` is 0, `ocp_trip` stays 0 whatever the comparators show.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_normal | input | 1 | 1 while the device is in normal power mode |
| vconn_closed | input | 1 | 1 while a VCONN switch is closed |
| cmp_inrush | input | 1 | Synchronized comparator output for the high inrush threshold |
| cmp_normal | input | 1 | Synchronized comparator output for the normal threshold |
| seq_alarm | input | 1 | 1 while the fault sequencer is in alarm state |
| ocp_trip | output | 1 | Single-cycle overcurrent trip pulse |

## Verification
A wrong window phase shows at `ocp_trip` as a trip arriving one or more cycles off the exact switchover edge. It also shows as a trip on the wrong comparator, visible in the first cycle after the comparator input changes. A window counter that does not restart on re-closure or on re-entry to normal mode makes the normal-threshold trip appear early, within one window length. A stuck or missing one-shot flag shows up in the very next cycle, as a second pulse or as a pulse lost after the alarm falls.

// File: rtl/vcocp_pkg.sv
package vcocp_pkg;

    // Phase of the soft-start window.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SOFT = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

    // Synchronized comparator pair from the analog sense path.
    typedef struct packed {
        logic hi;   // inrush threshold exceeded
        logic lo;   // normal threshold exceeded
    } cmp_s;

    // Qualifying context for monitoring.
    typedef struct packed {
        logic normal;
        logic closed;
    } ctx_s;

    function automatic int unsigned win_from_us(int unsigned mhz, int unsigned us);
        return mhz * us;
    endfunction

    // Comparator that counts in the given phase.
    function automatic logic pick_cmp(phase_e ph, cmp_s c);
        case (ph)
            PH_SOFT: return c.hi;
            PH_RUN:  return c.lo;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/vcocp_window.sv
module vcocp_window
    import vcocp_pkg::*;
#(
    parameter int unsigned WIN_CYCLES = 150000
) (
    input  logic   clk,
    input  logic   rst,
    input  ctx_s   ctx,
    output phase_e phase
);
    localparam int unsigned CW = $clog2(WIN_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          enable;

    assign enable = ctx.normal & ctx.closed;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    phase <= PH_SOFT;
                    cnt   <= '0;
                end
                PH_SOFT: begin
                    if (cnt == LAST) phase <= PH_RUN;
                    else             cnt   <= cnt + 1'b1;
                end
                PH_RUN:  phase <= PH_RUN;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R8
    cancel_on_open_chk: assert property (@(posedge clk) disable iff (rst)
        !ctx.closed |=> phase == PH_IDLE);

    // R9
    cancel_off_normal_chk: assert property (@(posedge clk) disable iff (rst)
        !ctx.normal |=> phase == PH_IDLE);

    // R2
    window_open_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && enable) |=> (phase == PH_SOFT && cnt == '0));

    // R2
    window_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SOFT && cnt != LAST && enable) |=> phase == PH_SOFT);

    // R2
    run_after_soft_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN) |-> $past(phase) != PH_IDLE);

endmodule

// File: rtl/vcocp_select.sv
module vcocp_select
    import vcocp_pkg::*;
(
    input  phase_e phase,
    input  cmp_s   cmp,
    input  ctx_s   ctx,
    output logic   active
);
    always_comb begin
        active = ctx.normal & ctx.closed & pick_cmp(phase, cmp);
    end
endmodule

// File: rtl/vcocp_trip.sv
module vcocp_trip (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic alarm,
    output logic trip
);
    logic fired;
    logic fire;

    assign fire = active & ~fired & ~alarm;

    always_ff @(posedge clk) begin
        if (rst) begin
            trip  <= 1'b0;
            fired <= 1'b0;
        end else begin
            trip <= fire;
            if (!active)   fired <= 1'b0;
            else if (fire) fired <= 1'b1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !trip);

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        trip |=> !trip);

    // R7
    alarm_block_chk: assert property (@(posedge clk) disable iff (rst)
        alarm |=> !trip);

endmodule

// File: rtl/vconn_ocp_gate.sv
module vconn_ocp_gate
    import vcocp_pkg::*;
#(
    parameter int unsigned CLK_MHZ    = 250,
    parameter int unsigned WIN_US     = 600,
    parameter int unsigned WIN_CYCLES = win_from_us(CLK_MHZ, WIN_US)
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_normal,
    input  logic vconn_closed,
    input  logic cmp_inrush,
    input  logic cmp_normal,
    input  logic seq_alarm,
    output logic ocp_trip
);
    ctx_s   ctx;
    cmp_s   cmp;
    phase_e phase;
    logic   active;

    assign ctx = '{normal: pwr_normal, closed: vconn_closed};
    assign cmp = '{hi: cmp_inrush, lo: cmp_normal};

    vcocp_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
        .clk   (clk),
        .rst   (rst),
        .ctx   (ctx),
        .phase (phase)
    );

    vcocp_select u_sel (
        .phase  (phase),
        .cmp    (cmp),
        .ctx    (ctx),
        .active (active)
    );

    vcocp_trip u_trip (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .alarm  (seq_alarm),
        .trip   (ocp_trip)
    );

    // R3
    soft_ignores_normal_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SOFT && !cmp_inrush) |=> !ocp_trip);

    // R10
    open_no_trip_chk: assert property (@(posedge clk) disable iff (rst)
        !vconn_closed |=> !ocp_trip);

    // R9
    off_mode_no_trip_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_normal |=> !ocp_trip);

endmodule

// File: tb/sim_vconn_ocp_gate.sv
module sim_vconn_ocp_gate;
    localparam int unsigned WIN = 6;

    logic clk = 1'b0;
    logic rst, pwr_normal, vconn_closed, cmp_inrush, cmp_normal, seq_alarm;
    logic ocp_trip;
    int   total = 0;
    int   bad   = 0;
    logic done  = 1'b0;

    always #2 clk = ~clk;

    vconn_ocp_gate #(.WIN_CYCLES(WIN)) u0 (
        .clk          (clk),
        .rst          (rst),
        .pwr_normal   (pwr_normal),
        .vconn_closed (vconn_closed),
        .cmp_inrush   (cmp_inrush),
        .cmp_normal   (cmp_normal),
        .seq_alarm    (seq_alarm),
        .ocp_trip     (ocp_trip)
    );

    // {req[3:0], normal, closed, inrush, normal_cmp, alarm, expected trip}
    localparam logic [9:0] VEC [0:29] = '{
        {4'd2,  6'b110000},  // R2 window opens
        {4'd3,  6'b111001},  // R3 inrush trips in window
        {4'd6,  6'b111000},  // R6 one pulse only
        {4'd3,  6'b110100},  // R3 normal cmp ignored
        {4'd3,  6'b110100},
        {4'd3,  6'b110100},
        {4'd2,  6'b110100},  // R2 last window cycle
        {4'd4,  6'b110101},  // R4 normal threshold active
        {4'd6,  6'b110100},
        {4'd4,  6'b111000},  // R4 inrush alone no trip
        {4'd7,  6'b110110},  // R7 alarm blocks
        {4'd7,  6'b110110},
        {4'd7,  6'b110101},  // R7 alarm falls, trip
        {4'd10, 6'b100100},  // R10 switch open
        {4'd10, 6'b100100},
        {4'd8,  6'b110100},  // R8 reclose
        {4'd8,  6'b110100},
        {4'd8,  6'b100100},  // R8 cancel
        {4'd8,  6'b110100},  // R8 restart from zero
        {4'd8,  6'b110100},
        {4'd8,  6'b110100},
        {4'd8,  6'b110100},
        {4'd8,  6'b110100},
        {4'd8,  6'b110100},
        {4'd8,  6'b110100},
        {4'd8,  6'b110101},
        {4'd9,  6'b010100},  // R9 leave normal mode
        {4'd9,  6'b011100},
        {4'd9,  6'b111100},  // R9 fresh window
        {4'd9,  6'b111101}
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: ocp_trip=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic n, input logic c, input logic h,
                         input logic l, input logic a);
        pwr_normal = n; vconn_closed = c; cmp_inrush = h;
        cmp_normal = l; seq_alarm = a;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        drive(0, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: ocp_trip=%0b expected=finish", ocp_trip);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive(0, 0, 0, 0, 0);

        // R1: reset with every input asserted
        @(negedge clk);
        drive(1, 1, 1, 1, 0);
        repeat (3) begin
            @(negedge clk);
            chk("R1 during reset", ocp_trip, 1'b0);
        end
        rst = 1'b0;
        @(negedge clk);
        chk("R1 first cycle after reset", ocp_trip, 1'b0);

        // Table walk
        do_reset();
        for (int i = 0; i < 30; i++) begin
            drive(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
            @(negedge clk);
            chk($sformatf("R%0d row %0d", VEC[i][9:6], i), ocp_trip, VEC[i][0]);
        end

        // R2/R4: exact switchover cycle
        do_reset();
        drive(1, 1, 0, 1, 0);
        for (int k = 1; k <= int'(WIN) + 3; k++) begin
            @(negedge clk);
            if (k == int'(WIN) + 1)      chk("R2 no trip before switchover", ocp_trip, 1'b0);
            else if (k == int'(WIN) + 2) chk("R4 trip at switchover", ocp_trip, 1'b1);
            else if (k == int'(WIN) + 3) chk("R6 pulse ends", ocp_trip, 1'b0);
            else if (ocp_trip !== 1'b0)  chk("R3 early trip", ocp_trip, 1'b0);
        end

        // R5: one-cycle latency during the window
        do_reset();
        drive(1, 1, 0, 0, 0);
        repeat (2) @(negedge clk);
        cmp_inrush = 1'b1;
        @(negedge clk);
        chk("R5 latency inrush", ocp_trip, 1'b1);
        @(negedge clk);
        chk("R6 single pulse", ocp_trip, 1'b0);

        // R7: alarm held through window end, then released
        do_reset();
        drive(1, 1, 0, 1, 1);
        repeat (int'(WIN) + 4) @(negedge clk);
        chk("R7 alarm holds off trip", ocp_trip, 1'b0);
        seq_alarm = 1'b0;
        @(negedge clk);
        chk("R7 trip after alarm release", ocp_trip, 1'b1);

        // R10: switch open, comparators high
        do_reset();
        drive(1, 0, 1, 1, 0);
        repeat (int'(WIN) + 4) @(negedge clk);
        chk("R10 open switch no trip", ocp_trip, 1'b0);

        // R9: not in normal mode
        do_reset();
        drive(0, 1, 1, 1, 0);
        repeat (int'(WIN) + 4) @(negedge clk);
        chk("R9 off-mode no trip", ocp_trip, 1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule